// File: doc/BRIEF.md
# Write-Through Register File

This block is the general-purpose register file of a pipelined processor's decode stage. It holds 32 words of 32 bits, offers two read ports whose data follows the address with no clock in between, and takes one write per cycle on the rising clock edge. Word 0 is hard-wired to zero.

A write and a read of the same word in the same cycle behave as if the write landed in the first half of the cycle and the read sampled in the second half. The read port returns the incoming write data at once, so an instruction in decode sees the value being retired by write-back in that same cycle. The datapath needs no separate write-back-to-decode forwarding path. Each read port makes this choice on its own.

Top module: `wt_regfile`

## Requirements
- R1: While `rst_n` is low, every word is cleared to zero, and after release every address reads zero until it is written.
- R2: With `wr_en` high and `wr_addr` not 0, `wr_data` is stored on the rising clock edge and is returned by later reads of that address.
- R3: With `wr_en` low, no stored word changes and no port returns `wr_data`.
- R4: Address 0 always reads zero. A write to address 0 is discarded, and a same-cycle read of address 0 does not take the write data.
- R5: When `wr_en` is high, `wr_addr` is not 0 and `rd_addr_a` equals `wr_addr`, `rd_data_a` shows `wr_data` in that same cycle.
- R6: Port B applies the same-cycle rule of R5 with `rd_addr_b` and `rd_data_b`, independently of port A. Both ports may take the write data together.
- R7: A read of an address different from `wr_addr` returns the stored word, unaffected by the write in progress.
- R8: Read data follows a change of read address within the same cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge commits writes |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr_a | input | 5 | Read port A address |
| rd_data_a | output | 32 | Read port A data |
| rd_addr_b | input | 5 | Read port B address |
| rd_data_b | output | 32 | Read port B data |

## Verification
A write-back and a decode read can fall in the same cycle. The interesting case is when they target the same word on one port, on both ports, or on word 0. The bench sets up these overlaps by driving write and read addresses together in one half period. It judges the read data before the edge, against the value being written, or against the old word when the addresses differ. After the edge it reads back the committed contents, which shows whether the write landed or was dropped.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int RF_WORDS_DEF = 32;
  localparam int RF_WIDTH_DEF = 32;

  function automatic int addr_bits(input int words);
    return (words > 1) ? $clog2(words) : 1;
  endfunction
endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
  parameter int NUM_REGS = rf_pkg::RF_WORDS_DEF,
  localparam int ADDR_W  = rf_pkg::addr_bits(NUM_REGS)
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [NUM_REGS-1:1] wr_sel
);
  // one enable per writable word; word 0 has no slot
  for (genvar i = 1; i < NUM_REGS; i++) begin : g_sel
    assign wr_sel[i] = wr_en && (wr_addr == ADDR_W'(i));
  end
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int NUM_REGS = rf_pkg::RF_WORDS_DEF,
  parameter int DATA_W   = rf_pkg::RF_WIDTH_DEF
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_REGS-1:1]              wr_sel,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q
);
  assign regs_q[0] = '0;

  for (genvar i = 1; i < NUM_REGS; i++) begin : g_word
    logic [DATA_W-1:0] word_d;

    always_comb begin
      word_d = regs_q[i];
      if (wr_sel[i]) word_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_q[i] <= '0;
      else        regs_q[i] <= word_d;
    end
  end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int NUM_REGS = rf_pkg::RF_WORDS_DEF,
  parameter int DATA_W   = rf_pkg::RF_WIDTH_DEF,
  localparam int ADDR_W  = rf_pkg::addr_bits(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic [DATA_W-1:0]               wr_data,
  input  logic [ADDR_W-1:0]               rd_addr,
  output logic [DATA_W-1:0]               rd_data
);
  logic hit_wr;
  logic in_range;

  assign hit_wr   = wr_en && (wr_addr == rd_addr) && (rd_addr != '0);
  assign in_range = (32'(rd_addr) < NUM_REGS);

  always_comb begin
    if (rd_addr == '0 || !in_range) rd_data = '0;
    else if (hit_wr)                rd_data = wr_data;
    else                            rd_data = regs_q[rd_addr];
  end
endmodule

// File: rtl/wt_regfile.sv
module wt_regfile #(
  parameter int NUM_REGS = rf_pkg::RF_WORDS_DEF,
  parameter int DATA_W   = rf_pkg::RF_WIDTH_DEF,
  localparam int ADDR_W  = rf_pkg::addr_bits(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  output logic [DATA_W-1:0] rd_data_b
);
  localparam int NUM_RD = 2;

  logic [NUM_REGS-1:1]             wr_sel;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
  logic [NUM_RD-1:0][ADDR_W-1:0]   rd_addr_v;
  logic [NUM_RD-1:0][DATA_W-1:0]   rd_data_v;

  rf_wr_decode #(.NUM_REGS(NUM_REGS)) u_dec (
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_sel (wr_sel)
  );

  rf_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_sel (wr_sel),
    .wr_data(wr_data),
    .regs_q (regs_q)
  );

  assign rd_addr_v[0] = rd_addr_a;
  assign rd_addr_v[1] = rd_addr_b;

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    rf_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_port (
      .regs_q (regs_q),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .rd_addr(rd_addr_v[p]),
      .rd_data(rd_data_v[p])
    );
  end

  assign rd_data_a = rd_data_v[0];
  assign rd_data_b = rd_data_v[1];
endmodule

// File: rtl/wt_regfile_chk.sv
module wt_regfile_chk #(
  parameter int NUM_REGS = rf_pkg::RF_WORDS_DEF,
  parameter int DATA_W   = rf_pkg::RF_WIDTH_DEF,
  localparam int ADDR_W  = rf_pkg::addr_bits(NUM_REGS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [ADDR_W-1:0] rd_addr_a,
  input logic [DATA_W-1:0] rd_data_a,
  input logic [ADDR_W-1:0] rd_addr_b,
  input logic [DATA_W-1:0] rd_data_b
);
  assert_zero_word_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_a == '0) |-> (rd_data_a == '0));

  assert_zero_word_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_b == '0) |-> (rd_data_b == '0));

  assert_same_cycle_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != '0 && rd_addr_a == wr_addr) |-> (rd_data_a == wr_data));

  assert_same_cycle_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != '0 && rd_addr_b == wr_addr) |-> (rd_data_b == wr_data));

  assert_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != '0) |=>
      ((rd_addr_a != $past(wr_addr)) || (wr_en && wr_addr == rd_addr_a) ||
       (rd_data_a == $past(wr_data))));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |=> (wr_en || !$stable(rd_addr_a) || $stable(rd_data_a)));
endmodule

bind wt_regfile wt_regfile_chk #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .rd_addr_a(rd_addr_a),
  .rd_data_a(rd_data_a),
  .rd_addr_b(rd_addr_b),
  .rd_data_b(rd_data_b)
);

// File: tb/wt_regfile_bench.sv
module wt_regfile_bench;
  typedef struct packed {
    logic        we;
    logic [4:0]  waddr;
    logic [31:0] wdata;
    logic [4:0]  ra;
    logic [4:0]  rb;
    logic [31:0] exp_a;
    logic [31:0] exp_b;
  } vec_t;

  localparam int NV = 10;
  // expected values follow from the requirements, applied in table order after reset
  localparam vec_t VECS [NV] = '{
    '{1'b1, 5'd3,  32'hAAAA0003, 5'd3,  5'd4,  32'hAAAA0003, 32'h0},         // R5, R7
    '{1'b1, 5'd4,  32'hBBBB0004, 5'd3,  5'd4,  32'hAAAA0003, 32'hBBBB0004},  // R2, R6
    '{1'b0, 5'd3,  32'hDEADBEEF, 5'd3,  5'd4,  32'hAAAA0003, 32'hBBBB0004},  // R3
    '{1'b1, 5'd0,  32'hFFFFFFFF, 5'd0,  5'd3,  32'h0,        32'hAAAA0003},  // R4
    '{1'b1, 5'd7,  32'h12345678, 5'd7,  5'd7,  32'h12345678, 32'h12345678},  // R6 both
    '{1'b1, 5'd3,  32'h00001111, 5'd3,  5'd7,  32'h00001111, 32'h12345678},  // R5 overwrite
    '{1'b0, 5'd0,  32'h0,        5'd3,  5'd0,  32'h00001111, 32'h0},         // R2, R4
    '{1'b1, 5'd31, 32'h80000001, 5'd31, 5'd30, 32'h80000001, 32'h0},         // R5 top word
    '{1'b0, 5'd0,  32'h0,        5'd31, 5'd4,  32'h80000001, 32'hBBBB0004},  // R2
    '{1'b1, 5'd4,  32'hCAFEF00D, 5'd3,  5'd4,  32'h00001111, 32'hCAFEF00D}   // R6, R7
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [4:0]  wr_addr;
  logic [31:0] wr_data;
  logic [4:0]  rd_addr_a;
  logic [31:0] rd_data_a;
  logic [4:0]  rd_addr_b;
  logic [31:0] rd_data_b;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  wt_regfile u_wt_regfile (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input logic we, input logic [4:0] wa, input logic [31:0] wd,
                       input logic [4:0] ra, input logic [4:0] rb);
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_addr_a = ra; rd_addr_b = rb;
    #2;
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr_a = '0; rd_addr_b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    drive(1'b0, 5'd0, 32'h0, 5'd5, 5'd31);
    check("R1 port a", rd_data_a, 32'h0);
    check("R1 port b", rd_data_b, 32'h0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].we, VECS[i].waddr, VECS[i].wdata, VECS[i].ra, VECS[i].rb);
      check($sformatf("R5/R6/R7 vec %0d port a", i), rd_data_a, VECS[i].exp_a);
      check($sformatf("R5/R6/R7 vec %0d port b", i), rd_data_b, VECS[i].exp_b);
    end

    // R8: address change with no clock edge in between
    drive(1'b0, 5'd0, 32'h0, 5'd7, 5'd31);
    check("R8 before", rd_data_a, 32'h12345678);
    rd_addr_a = 5'd4;
    #1;
    check("R8 after", rd_data_a, 32'hCAFEF00D);

    // R4: write to word 0 leaves it zero afterwards
    drive(1'b1, 5'd0, 32'h5A5A5A5A, 5'd1, 5'd0);
    check("R4 same cycle", rd_data_b, 32'h0);
    drive(1'b0, 5'd0, 32'h0, 5'd0, 5'd0);
    check("R4 after", rd_data_a, 32'h0);

    // R3: disabled write with matching address does not land
    drive(1'b0, 5'd9, 32'h77777777, 5'd9, 5'd9);
    check("R3 same cycle", rd_data_a, 32'h0);
    drive(1'b0, 5'd0, 32'h0, 5'd9, 5'd9);
    check("R3 after", rd_data_b, 32'h0);

    // R1: reset in mid-run clears written words
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b0, 5'd0, 32'h0, 5'd31, 5'd4);
    check("R1 word 31", rd_data_a, 32'h0);
    check("R1 word 4", rd_data_b, 32'h0);

    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule